// File: doc/BRIEF.md
# External Trigger Conditioner

This block turns a raw, asynchronous trigger pin into a clean level that a timer can count or react to. The pin is first brought into the kernel clock domain through a short flop chain. An optional edge-rate divider then slows fast signals by 2, 4 or 8. A digital filter then admits a new level only after it has been seen on a run of consecutive samples.

A 2-bit divider select sets the rate divider. A 4-bit filter select picks both the sampling interval, which is 1, 2, 4, 8, 16 or 32 kernel clocks, and the required run length N, which is between 2 and 8. The value zero turns filtering off. The block drives the accepted level, and a one-cycle pulse for every accepted low-to-high change. Consumers use the level for gating and the pulse for counting or triggering.

Top module: `trig_shaper`

## Requirements
- R1: While reset is asserted, and immediately after it, `trigLevel` and `trigRise` are both 0.
- R2: With `prescSel`=0 and `filtSel`=0, a change on `trigIn` made between clock edges shows on `trigLevel` at the fourth following rising clock edge: two edges for synchronisation, one for the rate divider and one for the output register.
- R3: `prescSel` sets the edge-rate divider to 1 (value 0), 2 (value 1), 4 (value 2) or 8 (value 3). For a divisor d greater than 1, the divided level toggles once every d/2 rising edges of the synchronised input, starting from 0 after reset. Sixteen input pulses therefore give 16/d output rising edges.
- R4: `filtSel` sets the sampling interval D in kernel clocks, and the run length N, as follows. Value 0: D=1, no filtering (N=1). Values 1, 2, 3: D=1, N=2, 4, 8. Values 4, 5: D=2, N=6, 8. Values 6, 7: D=4, N=6, 8. Values 8, 9: D=8, N=6, 8. Values 10, 11, 12: D=16, N=5, 6, 8. Values 13, 14, 15: D=32, N=5, 6, 8. Samples are taken once every D kernel clocks from a free-running counter, and `trigLevel` only changes on a sample.
- R5: `trigLevel` takes a new value only after N consecutive samples all show that value. After a held step on `trigIn`, the change appears between 4+(N-1)·D and 3+N·D clock edges later.
- R6: A sample that matches the current output level clears the run of matches. A high pulse that covers N-1 samples, followed by one low sample, is ignored, and the next rising step again needs the full N samples.
- R7: `trigRise` is high for exactly one clock, and only in the cycle in which `trigLevel` first reads 1 after an accepted rising change. Every accepted rising change produces one pulse.
- R8: An accepted falling change produces no pulse on `trigRise`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | 1 | Raw asynchronous trigger pin |
| prescSel | input | 2 | Edge-rate divider select |
| filtSel | input | 4 | Filter sampling interval and run-length select |
| trigLevel | output | 1 | Filtered trigger level |
| trigRise | output | 1 | One-cycle pulse on an accepted rising change |

## Verification
The assertions assume that the divided trigger toggles no faster than once every four kernel clocks. They also assume that the two select inputs only change while the filtered level is settled. Without the first, accepted changes could not be told apart from skipped ones. Without the second, a change of sampling interval could produce a sample at an unexpected time. The stimulus keeps to both assumptions: it drives pins only on falling clock edges, uses pulses eight clocks long, and changes the selects only after reset or after the output has settled.

// File: rtl/trig_shaper_pkg.sv
package trig_shaper_pkg;

  localparam int PRESC_SEL_W = 2;
  localparam int FILT_SEL_W  = 4;
  localparam int DIV_LOG_W   = 3;
  localparam int MAX_DIV_LOG = 5;
  localparam int DIV_CNT_W   = MAX_DIV_LOG;
  localparam int MATCH_W     = 3;
  localparam int PRESC_CNT_W = PRESC_SEL_W;

  // Strobes and limits passed from control to datapath.
  typedef struct packed {
    logic                   sampleEn;
    logic                   prescBypass;
    logic [PRESC_CNT_W-1:0] prescLim;
    logic [MATCH_W-1:0]     matchLast;
  } ctl_t;

  typedef struct packed {
    logic [DIV_LOG_W-1:0] divLog;
    logic [MATCH_W-1:0]   matchLast;
  } filt_cfg_t;

  // Sampling interval (as log2) and run length minus one per select value.
  function automatic filt_cfg_t decode_filter(input logic [FILT_SEL_W-1:0] code);
    filt_cfg_t c;
    case (code)
      4'd0:    c = '{divLog: 3'd0, matchLast: 3'd0};
      4'd1:    c = '{divLog: 3'd0, matchLast: 3'd1};
      4'd2:    c = '{divLog: 3'd0, matchLast: 3'd3};
      4'd3:    c = '{divLog: 3'd0, matchLast: 3'd7};
      4'd4:    c = '{divLog: 3'd1, matchLast: 3'd5};
      4'd5:    c = '{divLog: 3'd1, matchLast: 3'd7};
      4'd6:    c = '{divLog: 3'd2, matchLast: 3'd5};
      4'd7:    c = '{divLog: 3'd2, matchLast: 3'd7};
      4'd8:    c = '{divLog: 3'd3, matchLast: 3'd5};
      4'd9:    c = '{divLog: 3'd3, matchLast: 3'd7};
      4'd10:   c = '{divLog: 3'd4, matchLast: 3'd4};
      4'd11:   c = '{divLog: 3'd4, matchLast: 3'd5};
      4'd12:   c = '{divLog: 3'd4, matchLast: 3'd7};
      4'd13:   c = '{divLog: 3'd5, matchLast: 3'd4};
      4'd14:   c = '{divLog: 3'd5, matchLast: 3'd5};
      default: c = '{divLog: 3'd5, matchLast: 3'd7};
    endcase
    return c;
  endfunction

  // Rising edges counted before each toggle of the divided level, minus one.
  function automatic logic [PRESC_CNT_W-1:0] presc_limit(input logic [PRESC_SEL_W-1:0] code);
    logic [PRESC_CNT_W-1:0] lim;
    case (code)
      2'd2:    lim = 2'd1;
      2'd3:    lim = 2'd3;
      default: lim = 2'd0;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/trig_shaper_ctl.sv
module trig_shaper_ctl
  import trig_shaper_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PRESC_SEL_W-1:0] prescSel,
  input  logic [FILT_SEL_W-1:0]  filtSel,
  output ctl_t                   ctl
);

  filt_cfg_t            cfg;
  logic [DIV_CNT_W-1:0] divCnt;
  logic [DIV_CNT_W-1:0] divLim;
  logic                 sampleEn;

  always_comb begin
    cfg    = decode_filter(filtSel);
    divLim = DIV_CNT_W'((32'd1 << cfg.divLog) - 32'd1);
  end

  // A late limit (after a narrower select) samples at once and restarts.
  assign sampleEn = (divCnt >= divLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         divCnt <= '0;
    else if (sampleEn) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    ctl.sampleEn    = sampleEn;
    ctl.prescBypass = (prescSel == '0);
    ctl.prescLim    = presc_limit(prescSel);
    ctl.matchLast   = cfg.matchLast;
  end

endmodule

// File: rtl/trig_shaper_dp.sv
module trig_shaper_dp
  import trig_shaper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic clk,
  input  logic rstN,
  input  logic trigIn,
  input  ctl_t ctl,
  output logic trigLevel,
  output logic trigRise
);

  localparam int SYNC_LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncLvl;
  logic                   syncPrev;
  logic                   syncRise;
  logic [PRESC_CNT_W-1:0] edgeCnt;
  logic                   prescOut;
  logic [MATCH_W-1:0]     matchCnt;
  logic                   levelQ;
  logic                   riseQ;

  // Synchroniser chain; a single stage is a plain register.
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= trigIn;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], trigIn};
      end
    end
  endgenerate

  assign syncLvl  = syncQ[SYNC_LAST];
  assign syncRise = syncLvl && !syncPrev;

  // Edge-rate divider.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      edgeCnt  <= '0;
      prescOut <= 1'b0;
    end else begin
      syncPrev <= syncLvl;
      if (ctl.prescBypass) begin
        edgeCnt  <= '0;
        prescOut <= syncLvl;
      end else if (syncRise) begin
        if (edgeCnt >= ctl.prescLim) begin
          edgeCnt  <= '0;
          prescOut <= !prescOut;
        end else begin
          edgeCnt <= edgeCnt + 1'b1;
        end
      end
    end
  end

  // Run-length filter: the candidate is always the opposite of the output.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchCnt <= '0;
      levelQ   <= 1'b0;
      riseQ    <= 1'b0;
    end else begin
      riseQ <= 1'b0;
      if (ctl.sampleEn) begin
        if (prescOut == levelQ) begin
          matchCnt <= '0;
        end else if (matchCnt >= ctl.matchLast) begin
          matchCnt <= '0;
          levelQ   <= prescOut;
          riseQ    <= prescOut;
        end else begin
          matchCnt <= matchCnt + 1'b1;
        end
      end
    end
  end

  assign trigLevel = levelQ;
  assign trigRise  = riseQ;

endmodule

// File: rtl/trig_shaper.sv
module trig_shaper
  import trig_shaper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   trigIn,
  input  logic [PRESC_SEL_W-1:0] prescSel,
  input  logic [FILT_SEL_W-1:0]  filtSel,
  output logic                   trigLevel,
  output logic                   trigRise
);

  ctl_t ctl;
  logic sampleTap;

  trig_shaper_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .prescSel (prescSel),
    .filtSel  (filtSel),
    .ctl      (ctl)
  );

  trig_shaper_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .trigIn    (trigIn),
    .ctl       (ctl),
    .trigLevel (trigLevel),
    .trigRise  (trigRise)
  );

  assign sampleTap = ctl.sampleEn;

endmodule

// File: rtl/trig_shaper_chk.sv
module trig_shaper_chk (
  input logic clk,
  input logic rstN,
  input logic trigLevel,
  input logic trigRise,
  input logic sampleTap
);

  // R7: the pulse lasts a single cycle
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    trigRise |=> !trigRise);

  // R7: a pulse only accompanies a fresh high level
  a_r7_pulse_marks_edge: assert property (@(posedge clk) disable iff (!rstN)
    trigRise |-> (trigLevel && !$past(trigLevel)));

  // R7: every rise of the level carries a pulse
  a_r7_edge_has_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigLevel) |-> trigRise);

  // R8: falling changes are silent
  a_r8_no_pulse_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trigLevel) |-> !trigRise);

  // R4: the level moves only on a sample strobe
  a_r4_change_on_sample: assert property (@(posedge clk) disable iff (!rstN)
    (trigLevel != $past(trigLevel)) |-> $past(sampleTap));

endmodule

bind trig_shaper trig_shaper_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .trigLevel (trigLevel),
  .trigRise  (trigRise),
  .sampleTap (sampleTap)
);

// File: tb/trig_shaper_tb.sv
module trig_shaper_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       trigIn = 1'b0;
  logic [1:0] prescSel = 2'd0;
  logic [3:0] filtSel = 4'd0;
  logic       trigLevel;
  logic       trigRise;

  int  checks = 0;
  int  fails = 0;
  int  riseCount = 0;
  int  badPulse = 0;
  logic prevLvl = 1'b0;

  always #5 clk = ~clk;

  trig_shaper u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .trigIn    (trigIn),
    .prescSel  (prescSel),
    .filtSel   (filtSel),
    .trigLevel (trigLevel),
    .trigRise  (trigRise)
  );

  // Pulse monitor sampled away from the active edge (R7, R8).
  always @(negedge clk) begin
    if (!rstN) begin
      prevLvl = 1'b0;
    end else begin
      if (trigRise) riseCount++;
      if (trigRise && !(trigLevel && !prevLvl)) badPulse++;
      if (!trigRise && trigLevel && !prevLvl) badPulse++;
      prevLvl = trigLevel;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Drive a step and count clock edges until the output follows.
  task automatic stepAndMeasure(input logic tgt, output int lat);
    @(negedge clk);
    trigIn = tgt;
    lat = 0;
    while (trigLevel !== tgt && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // Sampling interval and run length from the select table of R4.
  task automatic filtExpect(input int code, output int d, output int n);
    case (code)
      0:  begin d = 1;  n = 1; end
      1:  begin d = 1;  n = 2; end
      2:  begin d = 1;  n = 4; end
      3:  begin d = 1;  n = 8; end
      4:  begin d = 2;  n = 6; end
      5:  begin d = 2;  n = 8; end
      6:  begin d = 4;  n = 6; end
      7:  begin d = 4;  n = 8; end
      8:  begin d = 8;  n = 6; end
      9:  begin d = 8;  n = 8; end
      10: begin d = 16; n = 5; end
      11: begin d = 16; n = 6; end
      12: begin d = 16; n = 8; end
      13: begin d = 32; n = 5; end
      14: begin d = 32; n = 6; end
      default: begin d = 32; n = 8; end
    endcase
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int lat, base, d, n, lo, hi, w;

    // R1: outputs cleared in and right after reset
    repeat (2) @(negedge clk);
    check(trigLevel == 1'b0, "R1 level in reset", trigLevel, 0);
    check(trigRise == 1'b0, "R1 pulse in reset", trigRise, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(trigLevel == 1'b0 && trigRise == 1'b0, "R1 after release", {trigLevel, trigRise}, 0);

    // R2: exact pass-through latency
    stepAndMeasure(1'b1, lat);
    check(lat == 4, "R2 rise latency", lat, 4);
    stepAndMeasure(1'b0, lat);
    check(lat == 4, "R2 fall latency", lat, 4);

    // R3: each divider setting with sixteen pulses of eight clocks
    for (int p = 0; p < 4; p++) begin
      prescSel = 2'(p);
      filtSel  = 4'd0;
      trigIn   = 1'b0;
      doReset();
      base = riseCount;
      repeat (16) begin
        trigIn = 1'b1;
        repeat (4) @(negedge clk);
        trigIn = 1'b0;
        repeat (4) @(negedge clk);
      end
      repeat (20) @(negedge clk);
      check(riseCount - base == (16 >> p), "R3 divided rising edges", riseCount - base, 16 >> p);
      check(trigLevel == 1'b0, "R3 final divided level", trigLevel, 0);
    end

    // R4 R5 R6 R7 R8: sweep of all filter selects
    prescSel = 2'd0;
    trigIn   = 1'b0;
    doReset();
    for (int f = 0; f < 16; f++) begin
      filtSel = 4'(f);
      filtExpect(f, d, n);
      lo = 4 + (n - 1) * d;
      hi = 3 + n * d;
      repeat (40) @(negedge clk);

      base = riseCount;
      stepAndMeasure(1'b1, lat);
      checkRange($sformatf("R4 R5 rise latency sel=%0d", f), lat, lo, hi);
      repeat (2) @(negedge clk);
      check(riseCount - base == 1, $sformatf("R7 one pulse sel=%0d", f), riseCount - base, 1);

      base = riseCount;
      stepAndMeasure(1'b0, lat);
      checkRange($sformatf("R5 fall latency sel=%0d", f), lat, lo, hi);
      repeat (2) @(negedge clk);
      check(riseCount - base == 0, $sformatf("R8 no pulse on fall sel=%0d", f), riseCount - base, 0);

      if (n > 1) begin
        w = (n - 1) * d;
        @(negedge clk);
        trigIn = 1'b1;
        repeat (w) @(negedge clk);
        trigIn = 1'b0;
        repeat (d) @(negedge clk);
        stepAndMeasure(1'b1, lat);
        checkRange($sformatf("R6 run restarts sel=%0d", f), lat, lo, hi);
        stepAndMeasure(1'b0, lat);
        repeat (2) @(negedge clk);
      end
    end

    check(badPulse == 0, "R7 pulse only with fresh high level", badPulse, 0);
    summary();
    $finish;
  end

endmodule